// File: doc/BRIEF.md
# PLL Hold and Reset Controller

This block is the control logic behind a single active-low control input of a PLL. The request can come from an external pin or from a configuration register bit. A second configuration bit gives the request one of two meanings. In reset mode it tri-states the charge pump, clears every divider counter and holds the outputs static. In hold mode it tri-states only the charge pump and leaves the outputs running. This gives external control over frequency hold-over.

The block runs in the reference-clock domain. It brings the asynchronous pin into that domain through a synchroniser before decoding it. When the request goes away, the charge pump is not re-enabled at once. The block waits for the first reference cycle that is flagged valid, and keeps the pump tri-stated for as long as no valid reference is present. A two-bit state output reports which phase the controller is in.

Top module: `pll_hold_ctrl`

## Requirements
- R1: While `rst_ni` is low and on release, the state is RESET (`state_o` = 2'b01) with `cp_tristate_o`, `cnt_clr_o` and `force_static_o` all 1.
- R2: A request is active when the synchronised pin is 0 or `ctl_reg_ni` is 0. With both at 1, including the pin's idle level of 1, no request is active.
- R3: A change on `ctl_pin_ni` reaches `state_o` on the third rising clock edge after it. A change on `ctl_reg_ni` reaches `state_o` on the next rising edge.
- R4: With `func_hold_i` = 0, an active request gives state RESET (2'b01). In that state `cp_tristate_o`, `cnt_clr_o` and `force_static_o` are all 1.
- R5: With `func_hold_i` = 1, an active request gives state HOLD (2'b10). In that state `cp_tristate_o` is 1 and both `cnt_clr_o` and `force_static_o` are 0.
- R6: When the request is released from RESET or HOLD, the state becomes WAIT (2'b11), with `cp_tristate_o` = 1 and the other two controls at 0. The counter clear therefore drops on a single edge.
- R7: WAIT moves to NORMAL (2'b00) on the first edge where `ref_valid_i` is 1, and stays in WAIT while it is 0. In NORMAL all three controls are 0.
- R8: `ref_valid_i` has no effect in RESET, HOLD or NORMAL.
- R9: If `func_hold_i` changes while a request is active, the state changes between RESET and HOLD on the next edge.
- R10: `static_se_o[i]` equals `se_invert_i[i]` while `force_static_o` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_pin_ni | input | 1 | Asynchronous active-low control pin |
| ctl_reg_ni | input | 1 | Active-low register request bit |
| func_hold_i | input | 1 | 0 = reset function, 1 = hold function |
| ref_valid_i | input | 1 | Reference clock valid in this cycle |
| se_invert_i | input | NUM_SE | Per-output inversion of single-ended outputs |
| cp_tristate_o | output | 1 | Charge pump tri-state enable |
| cnt_clr_o | output | 1 | Synchronous divider counter clear |
| force_static_o | output | 1 | Force all outputs static |
| static_se_o | output | NUM_SE | Static level for single-ended outputs |
| state_o | output | 2 | 00 normal, 01 reset, 10 hold, 11 wait |

## Verification
A sequence of vectors steps the controller through each path: reset release with a valid and with an invalid reference, hold release with the reference absent and then present, and a change of function while a request is held. Repeated WAIT vectors with `ref_valid_i` low separate a design that waits for the reference from one that resumes at once. Vectors with `ref_valid_i` high in HOLD and NORMAL show that the flag is ignored outside WAIT. Directed tests drive the pin alone and count edges to tell a two-stage synchroniser from a shorter or longer one, and compare the static single-ended levels against the inversion mask.

// File: rtl/pll_hold_pkg.sv
package pll_hold_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'b00,
    ST_RESET  = 2'b01,
    ST_HOLD   = 2'b10,
    ST_WAIT   = 2'b11
  } hold_state_e;
endpackage

// File: rtl/phc_sync.sv
module phc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/phc_fsm.sv
module phc_fsm
  import pll_hold_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        func_hold_i,
  input  logic        ref_valid_i,
  output hold_state_e state_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (req_i) begin
      state_d = func_hold_i ? ST_HOLD : ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET, ST_HOLD: state_d = ST_WAIT;
        ST_WAIT:           state_d = ref_valid_i ? ST_NORMAL : ST_WAIT;
        default:           state_d = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !req_i && !ref_valid_i) |=> state_q == ST_WAIT);
  // R7
  wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !req_i && ref_valid_i) |=> state_q == ST_NORMAL);
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RESET || state_q == ST_HOLD) && !req_i) |=> state_q == ST_WAIT);
  // R9
  func_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (state_q == ST_HOLD) == $past(func_hold_i));
endmodule

// File: rtl/phc_outs.sv
module phc_outs
  import pll_hold_pkg::*;
#(
  parameter int unsigned NUM_SE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hold_state_e       state_i,
  input  logic [NUM_SE-1:0] se_invert_i,
  output logic              cp_tristate_o,
  output logic              cnt_clr_o,
  output logic              force_static_o,
  output logic [NUM_SE-1:0] static_se_o
);
  assign cp_tristate_o  = (state_i != ST_NORMAL);
  assign cnt_clr_o      = (state_i == ST_RESET);
  assign force_static_o = (state_i == ST_RESET);

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    assign static_se_o[i] = force_static_o & se_invert_i[i];
  end

  // R4
  clr_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |-> cp_tristate_o);
  // R6
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnt_clr_o) |-> (cp_tristate_o && !force_static_o));
endmodule

// File: rtl/pll_hold_ctrl.sv
module pll_hold_ctrl
  import pll_hold_pkg::*;
#(
  parameter int unsigned NUM_SE      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_pin_ni,
  input  logic              ctl_reg_ni,
  input  logic              func_hold_i,
  input  logic              ref_valid_i,
  input  logic [NUM_SE-1:0] se_invert_i,
  output logic              cp_tristate_o,
  output logic              cnt_clr_o,
  output logic              force_static_o,
  output logic [NUM_SE-1:0] static_se_o,
  output logic [1:0]        state_o
);
  logic        pin_sync_n;
  logic        req;
  hold_state_e state;

  phc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_pin_ni),
    .q_o   (pin_sync_n)
  );

  // Either source low requests the function
  assign req = ~pin_sync_n | ~ctl_reg_ni;

  phc_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .func_hold_i(func_hold_i),
    .ref_valid_i(ref_valid_i),
    .state_o    (state)
  );

  phc_outs #(.NUM_SE(NUM_SE)) i_outs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .se_invert_i   (se_invert_i),
    .cp_tristate_o (cp_tristate_o),
    .cnt_clr_o     (cnt_clr_o),
    .force_static_o(force_static_o),
    .static_se_o   (static_se_o)
  );

  assign state_o = state;

  // R2
  reg_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_reg_ni |=> state_o inside {2'b01, 2'b10});
endmodule

// File: tb/test_pll_hold_ctrl.sv
module test_pll_hold_ctrl;
  localparam int NSE = 4;
  localparam int NV  = 13;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pin_n = 1'b1, reg_n = 1'b1, hold = 1'b0, refv = 1'b0;
  logic [NSE-1:0] inv = 4'b1010;
  logic cp_tri, clr, fst;
  logic [NSE-1:0] sse;
  logic [1:0] st;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  pll_hold_ctrl #(.NUM_SE(NSE)) i_pll_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_pin_ni(pin_n), .ctl_reg_ni(reg_n),
    .func_hold_i(hold), .ref_valid_i(refv), .se_invert_i(inv),
    .cp_tristate_o(cp_tri), .cnt_clr_o(clr), .force_static_o(fst),
    .static_se_o(sse), .state_o(st)
  );

  // {reg_n, hold, refv, expected state}
  localparam logic [4:0] VEC [NV] = '{
    {3'b100, 2'b11}, {3'b100, 2'b11}, {3'b101, 2'b00}, {3'b011, 2'b10},
    {3'b010, 2'b10}, {3'b111, 2'b11}, {3'b110, 2'b11}, {3'b111, 2'b00},
    {3'b001, 2'b01}, {3'b011, 2'b10}, {3'b000, 2'b01}, {3'b101, 2'b11},
    {3'b101, 2'b00}
  };

  task automatic check(input logic [1:0] exp, input string req);
    logic [2:0] got, want;
    logic [NSE-1:0] wse;
    tests++;
    want = {exp != 2'b00, exp == 2'b01, exp == 2'b01};
    wse  = (exp == 2'b01) ? inv : '0;
    got  = {cp_tri, clr, fst};
    if (st !== exp || got !== want || sse !== wse) begin
      fails++;
      $display("FAIL %s: state=%b ctl=%b se=%b expected state=%b ctl=%b se=%b",
               req, st, got, sse, exp, want, wse);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20;
    check(2'b01, "R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    check(2'b01, "R1 after release");

    // R4 R5 R6 R7 R8 R9 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      {reg_n, hold, refv} = VEC[i][4:2];
      step();
      check(VEC[i][1:0], $sformatf("R4-vector %0d", i));
    end

    // R3 pin path, reset function: state moves on third edge
    hold = 1'b0; refv = 1'b0; reg_n = 1'b1;
    pin_n = 1'b0;
    step(); check(2'b00, "R3 pin edge1");
    step(); check(2'b00, "R3 pin edge2");
    step(); check(2'b01, "R3 pin edge3 R2");
    pin_n = 1'b1;
    step(); check(2'b01, "R3 release edge1");
    step(); check(2'b01, "R3 release edge2");
    step(); check(2'b11, "R3 release edge3 R6");
    // R8 ref_valid ignored in HOLD
    refv = 1'b1; step(); check(2'b00, "R7 resume");
    hold = 1'b1; reg_n = 1'b0; step(); check(2'b10, "R5 hold");
    refv = 1'b1; step(); check(2'b10, "R8 refv in hold");
    refv = 1'b0; reg_n = 1'b1; step(); check(2'b11, "R6 hold release");
    step(); check(2'b11, "R7 wait no ref");
    // R10 other inversion mask
    inv = 4'b0111; hold = 1'b0; reg_n = 1'b0; step();
    check(2'b01, "R10 mask");
    // R1 async reset mid-run
    reg_n = 1'b1; refv = 1'b1; step(); step();
    rst_ni = 1'b0; #1;
    check(2'b01, "R1 async reset");
    rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule